// File: doc/BRIEF.md
# Front-Panel Memory Loader

This block is an operator console for a small memory system. It takes over a 16-bit address bus from a processor so that bytes can be examined and deposited by hand, one at a time. While the console enable switch is on, the block asks the processor to hold off. Once the processor grants the bus, the block drives the address, the write data and the per-bank write strobes. When the enable switch is turned off, the block lets go of the bus and the processor runs again.

Twelve switches serve two purposes. A press of the address button copies all twelve switches into an address register. In write mode, a press of the data button stores the low eight switches at that address. The four upper address bits are always zero. The 4K reachable space is split into four banks, chosen by address bits 11 and 10. Each bank has a write-protect input that blocks its strobe. A display vector shows the held address. A second display vector tracks the byte that memory returns at the address on the bus. Because the memory holds no program at power-up, a program is typically entered starting at address zero and the processor is then reset.

Top module: `panel_loader`

## Requirements
- R1: `hold_req` equals the enable switch delayed by one clock.
- R2: `bus_oe` is set only while the enable switch is on and `hold_req` and `hold_ack` were both high at the previous edge. While `bus_oe` is low, `mem_addr` and `mem_wdata` are zero and `bank_we` is all zero.
- R3: `mem_addr[15:12]` is always zero, and `disp_addr` is the address register zero-extended to 16 bits.
- R4: While `bus_oe` is high, an `addr_btn` pulse loads `sw_val` into the address register at the next edge. While `bus_oe` is high, that register drives `mem_addr[11:0]` whenever no write is in progress.
- R5: While `bus_oe` is high, `disp_data` takes the value of `mem_rdata` at every clock edge.
- R6: A `data_btn` pulse in write mode (`wr_mode` = 1) produces a one-clock strobe on `bank_we[b]`, where b = address[11:10]. During that clock `mem_wdata` carries `sw_val[7:0]`.
- R7: No strobe is produced for a bank whose `wprot` bit is 1 at the time of the press.
- R8: A `data_btn` pulse in read mode (`wr_mode` = 0) changes neither memory nor the display.
- R9: When `addr_btn` and `data_btn` arrive in the same clock, the write goes to the address held before the press, and the address register takes the new switch value.
- R10: The address register keeps its value across enable-off periods. Button pulses are ignored while `bus_oe` is low.
- R11: During reset, `hold_req`, `bus_oe`, `bank_we`, `mem_addr`, `disp_addr` and `disp_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pnl_en | input | 1 | Console enable switch |
| wr_mode | input | 1 | 1 = write mode, 0 = read mode |
| sw_val | input | 12 | Address/data switch bank |
| addr_btn | input | 1 | Debounced one-clock address-load pulse |
| data_btn | input | 1 | Debounced one-clock deposit pulse |
| hold_ack | input | 1 | Processor grants the bus |
| wprot | input | 4 | Per-bank write protect |
| mem_rdata | input | 8 | Byte read from memory at `mem_addr` |
| hold_req | output | 1 | Request that the processor hold off |
| bus_oe | output | 1 | Console is driving the bus |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| bank_we | output | 4 | One write strobe per bank |
| disp_addr | output | 16 | Address display |
| disp_data | output | 8 | Data display |

## Verification
An address load and a deposit can both land in the same clock. The write must then use the address that was held before the press, while the register takes the new switch value. The bench provokes this by pulsing both buttons together, with the switches set to a different address. It then reads back both the old and the new address through the displays. The old location must hold the deposited byte, and the new location must hold its preloaded value.

// File: rtl/panel_pkg.sv
package panel_pkg;
    typedef enum logic {
        PNL_READ  = 1'b0,
        PNL_WRITE = 1'b1
    } pnl_mode_e;
endpackage

// File: rtl/panel_bank_dec.sv
module panel_bank_dec #(
    parameter int N_BANK = 4,
    parameter int SEL_W  = 2
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [N_BANK-1:0] prot,
    input  logic              fire,
    output logic [N_BANK-1:0] we_vec
);
    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        assign we_vec[b] = fire && (sel == SEL_W'(b)) && !prot[b];
    end
endmodule

// File: rtl/panel_bus_mux.sv
module panel_bus_mux #(
    parameter int SW_W   = 12,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              oe,
    input  logic              wr_busy,
    input  logic [SW_W-1:0]   cur_addr,
    input  logic [SW_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata
);
    localparam int PAD_W = ADDR_W - SW_W;

    always_comb begin
        bus_addr  = '0;
        bus_wdata = '0;
        if (oe) begin
            bus_addr = {{PAD_W{1'b0}}, (wr_busy ? wr_addr : cur_addr)};
            if (wr_busy) begin
                bus_wdata = wr_data;
            end
        end
    end
endmodule

// File: rtl/panel_loader.sv
module panel_loader #(
    parameter int SW_W   = 12,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int N_BANK = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pnl_en,
    input  logic              wr_mode,
    input  logic [SW_W-1:0]   sw_val,
    input  logic              addr_btn,
    input  logic              data_btn,
    input  logic              hold_ack,
    input  logic [N_BANK-1:0] wprot,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              hold_req,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [N_BANK-1:0] bank_we,
    output logic [ADDR_W-1:0] disp_addr,
    output logic [DATA_W-1:0] disp_data
);
    import panel_pkg::*;

    localparam int SEL_W = $clog2(N_BANK);
    localparam int PAD_W = ADDR_W - SW_W;

    typedef struct packed {
        logic              hold;
        logic              oe;
        logic [SW_W-1:0]   addr;
        logic [SW_W-1:0]   wa;
        logic [DATA_W-1:0] wdata;
        logic [N_BANK-1:0] we;
        logic [DATA_W-1:0] disp;
    } pnl_st_t;

    pnl_st_t s_d, s_q;

    logic              own_d;
    logic              fire_d;
    logic [N_BANK-1:0] we_vec_d;

    assign own_d  = s_q.oe && pnl_en && hold_ack;
    assign fire_d = own_d && data_btn && (pnl_mode_e'(wr_mode) == PNL_WRITE);

    panel_bank_dec #(
        .N_BANK (N_BANK),
        .SEL_W  (SEL_W)
    ) u_dec (
        .sel    (s_q.addr[SW_W-1 -: SEL_W]),
        .prot   (wprot),
        .fire   (fire_d),
        .we_vec (we_vec_d)
    );

    always_comb begin
        s_d      = s_q;
        s_d.hold = pnl_en;
        s_d.oe   = s_q.hold && hold_ack && pnl_en;
        s_d.we   = we_vec_d;
        if (fire_d) begin
            s_d.wa    = s_q.addr;
            s_d.wdata = sw_val[DATA_W-1:0];
        end
        if (own_d && addr_btn) begin
            s_d.addr = sw_val;
        end
        if (s_q.oe) begin
            s_d.disp = mem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    panel_bus_mux #(
        .SW_W   (SW_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mux (
        .oe        (s_q.oe),
        .wr_busy   (|s_q.we),
        .cur_addr  (s_q.addr),
        .wr_addr   (s_q.wa),
        .wr_data   (s_q.wdata),
        .bus_addr  (mem_addr),
        .bus_wdata (mem_wdata)
    );

    assign hold_req  = s_q.hold;
    assign bus_oe    = s_q.oe;
    assign bank_we   = s_q.oe ? s_q.we : '0;
    assign disp_addr = {{PAD_W{1'b0}}, s_q.addr};
    assign disp_data = s_q.disp;
endmodule

// File: rtl/panel_loader_chk.sv
module panel_loader_chk #(
    parameter int SW_W   = 12,
    parameter int ADDR_W = 16,
    parameter int N_BANK = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pnl_en,
    input logic              wr_mode,
    input logic              data_btn,
    input logic              hold_ack,
    input logic [N_BANK-1:0] wprot,
    input logic              hold_req,
    input logic              bus_oe,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [N_BANK-1:0] bank_we
);
    localparam int SEL_W = $clog2(N_BANK);

    p_hold_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pnl_en |=> hold_req);

    p_hold_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pnl_en |=> !hold_req);

    p_oe_needs_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> $past(hold_req && hold_ack));

    p_quiet_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bank_we == '0 && mem_addr == '0));

    p_top_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr[ADDR_W-1:SW_W] == '0);

    p_we_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));

    p_we_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_we) |-> $past(data_btn && wr_mode));

    p_we_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_we) |-> bank_we[mem_addr[SW_W-1 -: SEL_W]]);

    p_protect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we & $past(wprot)) == '0);

    p_read_noop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(data_btn && !wr_mode) |-> bank_we == '0);
endmodule

bind panel_loader panel_loader_chk #(
    .SW_W   (SW_W),
    .ADDR_W (ADDR_W),
    .N_BANK (N_BANK)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pnl_en   (pnl_en),
    .wr_mode  (wr_mode),
    .data_btn (data_btn),
    .hold_ack (hold_ack),
    .wprot    (wprot),
    .hold_req (hold_req),
    .bus_oe   (bus_oe),
    .mem_addr (mem_addr),
    .bank_we  (bank_we)
);

// File: tb/panel_loader_tb_top.sv
module panel_loader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pnl_en = 1'b0;
    logic        wr_mode = 1'b0;
    logic [11:0] sw_val = '0;
    logic        addr_btn = 1'b0;
    logic        data_btn = 1'b0;
    logic        hold_ack;
    logic [3:0]  wprot = '0;
    logic [7:0]  mem_rdata;
    logic        hold_req, bus_oe;
    logic [15:0] mem_addr, disp_addr;
    logic [7:0]  mem_wdata, disp_data;
    logic [3:0]  bank_we;

    logic [7:0]  mem [0:4095];
    int          n_vec = 0;
    int          n_bad = 0;
    int          we_cycles = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    panel_loader dut_i (
        .clk(clk), .rst_n(rst_n), .pnl_en(pnl_en), .wr_mode(wr_mode),
        .sw_val(sw_val), .addr_btn(addr_btn), .data_btn(data_btn),
        .hold_ack(hold_ack), .wprot(wprot), .mem_rdata(mem_rdata),
        .hold_req(hold_req), .bus_oe(bus_oe), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .bank_we(bank_we), .disp_addr(disp_addr),
        .disp_data(disp_data)
    );

    // processor model: grants the bus one clock after the request
    always @(posedge clk) begin
        if (!rst_n) hold_ack <= 1'b0;
        else        hold_ack <= hold_req;
    end

    // memory model
    assign mem_rdata = mem[mem_addr[11:0]];
    always @(posedge clk) begin
        if (|bank_we) begin
            mem[mem_addr[11:0]] <= mem_wdata;
            we_cycles <= we_cycles + 1;
        end
    end

    typedef struct packed {
        logic        op;    // 0 = address press, 1 = data press
        logic        wr;
        logic [3:0]  prot;
        logic [11:0] sw;
        logic [15:0] ea;
        logic [7:0]  ed;
    } vec_t;

    // memory preload: byte i = i[7:0] ^ 8'hA5
    localparam vec_t VECS [10] = '{
        '{1'b0, 1'b0, 4'h0, 12'h000, 16'h0000, 8'hA5}, // R4 R5 load and read
        '{1'b1, 1'b1, 4'h0, 12'h03C, 16'h0000, 8'h3C}, // R6 deposit bank 0
        '{1'b0, 1'b0, 4'h0, 12'h401, 16'h0401, 8'hA4}, // R4 bank 1
        '{1'b1, 1'b1, 4'h2, 12'h0C7, 16'h0401, 8'hA4}, // R7 bank 1 protected
        '{1'b1, 1'b1, 4'hD, 12'h0C7, 16'h0401, 8'hC7}, // R7 R6 other banks protected
        '{1'b0, 1'b0, 4'h0, 12'hFFF, 16'h0FFF, 8'h5A}, // R3 top of space
        '{1'b1, 1'b0, 4'h0, 12'h011, 16'h0FFF, 8'h5A}, // R8 read-mode press
        '{1'b1, 1'b1, 4'h7, 12'h0EE, 16'h0FFF, 8'hEE}, // R6 bank 3
        '{1'b0, 1'b0, 4'h0, 12'h000, 16'h0000, 8'h3C}, // R5 readback
        '{1'b0, 1'b0, 4'h0, 12'h401, 16'h0401, 8'hC7}  // R5 readback
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input logic a, input logic d);
        @(negedge clk);
        addr_btn = a;
        data_btn = d;
        @(negedge clk);
        addr_btn = 1'b0;
        data_btn = 1'b0;
        wait_cyc(3);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i) ^ 8'hA5;
        wait_cyc(3);
        // R11 reset state
        check("R11 hold_req", 32'(hold_req), 0);
        check("R11 bus_oe", 32'(bus_oe), 0);
        check("R11 bank_we", 32'(bank_we), 0);
        check("R11 mem_addr", 32'(mem_addr), 0);
        check("R11 disp_addr", 32'(disp_addr), 0);
        check("R11 disp_data", 32'(disp_data), 0);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 R2 takeover sequence
        pnl_en = 1'b1;
        wait_cyc(1);
        check("R1 hold_req rises", 32'(hold_req), 1);
        check("R2 no drive before grant", 32'(bus_oe), 0);
        wait_cyc(2);
        check("R2 drive after grant", 32'(bus_oe), 1);
        wait_cyc(2);

        for (int v = 0; v < 10; v++) begin
            sw_val  = VECS[v].sw;
            wr_mode = VECS[v].wr;
            wprot   = VECS[v].prot;
            press(!VECS[v].op, VECS[v].op);
            check($sformatf("R4 vec%0d disp_addr", v), 32'(disp_addr), 32'(VECS[v].ea));
            check($sformatf("R5 vec%0d disp_data", v), 32'(disp_data), 32'(VECS[v].ed));
            check($sformatf("R3 vec%0d mem_addr", v), 32'(mem_addr), 32'(VECS[v].ea));
        end

        // R10 release, retain, ignore presses while released
        pnl_en = 1'b0;
        wait_cyc(1);
        check("R1 hold_req falls", 32'(hold_req), 0);
        check("R2 released bus_oe", 32'(bus_oe), 0);
        check("R2 released mem_addr", 32'(mem_addr), 0);
        sw_val  = 12'h123;
        wr_mode = 1'b1;
        wprot   = 4'h0;
        press(1'b1, 1'b1);
        check("R10 addr kept", 32'(disp_addr), 32'h0401);
        check("R10 no write while released", 32'(mem[12'h123]), 32'(8'h23 ^ 8'hA5));
        pnl_en = 1'b1;
        wait_cyc(5);
        check("R10 addr after re-enable", 32'(mem_addr), 32'h0401);

        // R9 same-cycle address load and deposit
        sw_val  = 12'h000;
        wr_mode = 1'b0;
        press(1'b1, 1'b0);
        sw_val  = 12'h802;
        wr_mode = 1'b1;
        press(1'b1, 1'b1);
        check("R9 new address", 32'(disp_addr), 32'h0802);
        check("R9 new location untouched", 32'(disp_data), 32'hA7);
        sw_val  = 12'h000;
        wr_mode = 1'b0;
        press(1'b1, 1'b0);
        check("R9 write went to old address", 32'(disp_data), 32'h02);

        // R6 R7 each effective deposit is exactly one strobe cycle
        check("R6 R7 strobe cycles", 32'(we_cycles), 4);
        summary();
    end
endmodule